// File: doc/BRIEF.md
# Zero-Voltage-Switching Flyback Gate Sequencer

This block drives the three gates of an isolated flyback power stage: the main primary switch, the active clamp switch and the synchronous rectifier. It runs at a constant switching period and a constant on-duty command, so the stage stays in discontinuous conduction and its average input current stays fixed. The block never modulates frequency. A single counter walks each switching cycle through six timed stretches:

- the main-switch on-time;
- a dead time after main turn-off;
- a joint clamp-and-rectifier conduction window;
- an all-off zero-current interval;
- a short rectifier-only pulse;
- a final all-off gap.

The rectifier-only pulse pulls the magnetizing current below zero. That negative current discharges the main switch's output capacitance before the main switch turns on.

The dead time before main turn-on is split into two programmable segments. In the first segment only the rectifier conducts. In the second segment every gate is low. Both segments are taken out of the on-duty command, so the main switch conducts for the command minus their sum. Software-side values for the period, the duty, the release window, the turn-off dead time and the two segments are sampled only at cycle boundaries.

If the programmed stretches do not fit in the period, the zero-current interval shrinks to nothing and a sticky error flag is raised.

Top module: `zvs_flyback_seq`

## Requirements
- R1: While `rst_n` is low, and from the second clock edge after `en` goes low, all three gates and `cyc_start` are low.
- R2: After `en` rises, every cycle begins with the main-switch on-interval. `cyc_start` is high for exactly the first clock of each cycle. A cycle lasts `period_cnt` clocks when the programmed stretches fit.
- R3: The main gate is high for `duty_cnt - (zvs_cnt + gap_cnt)` clocks at the start of the cycle, or for zero clocks if `duty_cnt` is not larger than that sum.
- R4: After the main gate falls, all gates stay low for `toff_dead_cnt` clocks.
- R5: After that, the clamp and rectifier gates are both high for `release_cnt` clocks.
- R6: After the release window, all gates are low for the rest of the cycle until the rectifier-only pulse.
- R7: The last `zvs_cnt + gap_cnt` clocks of each cycle are a rectifier-only pulse of `zvs_cnt` clocks, followed by `gap_cnt` clocks with all gates low.
- R8: The rectifier gate is the OR of the clamp gate and the rectifier-only pulse. The main gate is never high in the same clock as the clamp gate or the rectifier gate.
- R9: Changes to the setting inputs during a cycle take effect only from the next cycle start.
- R10: If the on-time, turn-off dead time, release window and both segments add up to more than `period_cnt`, the zero-current interval is dropped and the cycle lasts that sum. In that case `cfg_err` goes high at the cycle start and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low forces all gates off and restarts the cycle |
| period_cnt | input | CNT_W | Switching period in clocks |
| duty_cnt | input | CNT_W | On-duty reference in clocks, dead-time segments included |
| toff_dead_cnt | input | CNT_W | Dead time after main turn-off |
| release_cnt | input | CNT_W | Clamp and rectifier conduction window |
| zvs_cnt | input | CNT_W | Rectifier-only pulse length (first pre-turn-on segment) |
| gap_cnt | input | CNT_W | All-off gap before main turn-on (second segment) |
| g_main | output | 1 | Main switch gate |
| g_clamp | output | 1 | Active clamp gate |
| g_rect | output | 1 | Synchronous rectifier gate |
| cyc_start | output | 1 | One-clock strobe at each cycle start |
| cfg_err | output | 1 | Sticky flag for over-long programmed stretches |

## Verification
The bench builds the block with the default 12-bit counters and registered outputs. This lets it use short periods of 10 to 40 clocks, so each stretch of the cycle can be compared clock by clock against a scoreboard.

The settings chosen cover four cases:
- a duty too small to leave any on-time;
- a zero-length rectifier pulse;
- an overrun that stretches the cycle;
- a setting change in the middle of a cycle.

// File: rtl/zvs_seq_pkg.sv
package zvs_seq_pkg;
   typedef struct packed {
      logic main;
      logic clamp;
      logic rect;
      logic start;
   } gate_vec_t;

   localparam gate_vec_t GATES_OFF = '{main: 1'b0, clamp: 1'b0, rect: 1'b0, start: 1'b0};
endpackage

// File: rtl/zvs_seq_cfg.sv
module zvs_seq_cfg #(
   parameter int CNT_W = 12,
   localparam int SUM_W = CNT_W + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] per_in,
   input  logic [CNT_W-1:0] duty_in,
   input  logic [CNT_W-1:0] doff_in,
   input  logic [CNT_W-1:0] rel_in,
   input  logic [CNT_W-1:0] zvs_in,
   input  logic [CNT_W-1:0] gap_in,
   output logic [SUM_W-1:0] e_main,
   output logic [SUM_W-1:0] e_dead,
   output logic [SUM_W-1:0] e_rel,
   output logic [SUM_W-1:0] e_zero,
   output logic [SUM_W-1:0] e_zvs,
   output logic [SUM_W-1:0] len_m1,
   output logic             err
);
   logic [CNT_W-1:0] per_q, duty_q, doff_q, rel_q, zvs_q, gap_q;

   function automatic logic [SUM_W-1:0] on_len(input logic [CNT_W-1:0] d,
                                                input logic [CNT_W-1:0] a,
                                                input logic [CNT_W-1:0] b);
      logic [SUM_W-1:0] pre;
      pre = SUM_W'(a) + SUM_W'(b);
      return (SUM_W'(d) > pre) ? (SUM_W'(d) - pre) : '0;
   endfunction

   function automatic logic [SUM_W-1:0] busy_len(input logic [CNT_W-1:0] d,
                                                  input logic [CNT_W-1:0] o,
                                                  input logic [CNT_W-1:0] r,
                                                  input logic [CNT_W-1:0] a,
                                                  input logic [CNT_W-1:0] b);
      return on_len(d, a, b) + SUM_W'(o) + SUM_W'(r) + SUM_W'(a) + SUM_W'(b);
   endfunction

   logic in_ovf;
   assign in_ovf = busy_len(duty_in, doff_in, rel_in, zvs_in, gap_in) > SUM_W'(per_in);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_q  <= '0;
         duty_q <= '0;
         doff_q <= '0;
         rel_q  <= '0;
         zvs_q  <= '0;
         gap_q  <= '0;
         err    <= 1'b0;
      end else if (load) begin
         per_q  <= per_in;
         duty_q <= duty_in;
         doff_q <= doff_in;
         rel_q  <= rel_in;
         zvs_q  <= zvs_in;
         gap_q  <= gap_in;
         if (in_ovf) err <= 1'b1;
      end
   end

   logic [SUM_W-1:0] busy, len;
   always_comb begin
      e_main = on_len(duty_q, zvs_q, gap_q);
      e_dead = e_main + SUM_W'(doff_q);
      e_rel  = e_dead + SUM_W'(rel_q);
      busy   = e_rel + SUM_W'(zvs_q) + SUM_W'(gap_q);
      len    = (busy > SUM_W'(per_q)) ? busy : SUM_W'(per_q);
      if (len == '0) len = SUM_W'(1);
      e_zvs  = len - SUM_W'(gap_q);
      e_zero = e_zvs - SUM_W'(zvs_q);
      len_m1 = len - SUM_W'(1);
   end
endmodule

// File: rtl/zvs_seq_timer.sv
module zvs_seq_timer #(
   parameter int CNT_W = 12,
   localparam int SUM_W = CNT_W + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SUM_W-1:0] len_m1,
   output logic [SUM_W-1:0] cnt,
   output logic             active,
   output logic             load
);
   assign load = !active || (cnt == len_m1);

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt    <= '0;
         active <= 1'b0;
      end else if (!active) begin
         cnt    <= '0;
         active <= 1'b1;
      end else if (cnt == len_m1) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + SUM_W'(1);
      end
   end
endmodule

// File: rtl/zvs_seq_gate.sv
module zvs_seq_gate
   import zvs_seq_pkg::*;
#(
   parameter int CNT_W   = 12,
   parameter bit OUT_REG = 1'b1,
   localparam int SUM_W  = CNT_W + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             active,
   input  logic [SUM_W-1:0] cnt,
   input  logic [SUM_W-1:0] e_main,
   input  logic [SUM_W-1:0] e_dead,
   input  logic [SUM_W-1:0] e_rel,
   input  logic [SUM_W-1:0] e_zero,
   input  logic [SUM_W-1:0] e_zvs,
   output gate_vec_t        gates
);
   gate_vec_t nxt;
   logic      run, clamp_win, zvs_win;

   always_comb begin
      run       = active && en && rst_n;
      clamp_win = (cnt >= e_dead) && (cnt < e_rel);
      zvs_win   = (cnt >= e_zero) && (cnt < e_zvs);
      nxt       = GATES_OFF;
      if (run) begin
         nxt.main  = cnt < e_main;
         nxt.clamp = clamp_win;
         nxt.rect  = clamp_win || zvs_win;
         nxt.start = cnt == '0;
      end
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) gates <= GATES_OFF;
            else        gates <= nxt;
         end
      end else begin : g_comb
         assign gates = nxt;
      end
   endgenerate
endmodule

// File: rtl/zvs_flyback_seq.sv
module zvs_flyback_seq
   import zvs_seq_pkg::*;
#(
   parameter int CNT_W   = 12,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] period_cnt,
   input  logic [CNT_W-1:0] duty_cnt,
   input  logic [CNT_W-1:0] toff_dead_cnt,
   input  logic [CNT_W-1:0] release_cnt,
   input  logic [CNT_W-1:0] zvs_cnt,
   input  logic [CNT_W-1:0] gap_cnt,
   output logic             g_main,
   output logic             g_clamp,
   output logic             g_rect,
   output logic             cyc_start,
   output logic             cfg_err
);
   localparam int SUM_W = CNT_W + 3;

   generate
      if (CNT_W < 4 || CNT_W > 28) begin : g_bad_w
         $error("zvs_flyback_seq: CNT_W out of supported range");
      end
   endgenerate

   logic [SUM_W-1:0] e_main, e_dead, e_rel, e_zero, e_zvs, len_m1, cnt;
   logic             active, load;
   gate_vec_t        gates;

   zvs_seq_cfg #(.CNT_W(CNT_W)) cfg_i (
      .clk(clk), .rst_n(rst_n), .load(load),
      .per_in(period_cnt), .duty_in(duty_cnt), .doff_in(toff_dead_cnt),
      .rel_in(release_cnt), .zvs_in(zvs_cnt), .gap_in(gap_cnt),
      .e_main(e_main), .e_dead(e_dead), .e_rel(e_rel), .e_zero(e_zero),
      .e_zvs(e_zvs), .len_m1(len_m1), .err(cfg_err)
   );

   zvs_seq_timer #(.CNT_W(CNT_W)) tmr_i (
      .clk(clk), .rst_n(rst_n), .en(en), .len_m1(len_m1),
      .cnt(cnt), .active(active), .load(load)
   );

   zvs_seq_gate #(.CNT_W(CNT_W), .OUT_REG(OUT_REG)) gate_i (
      .clk(clk), .rst_n(rst_n), .en(en), .active(active), .cnt(cnt),
      .e_main(e_main), .e_dead(e_dead), .e_rel(e_rel), .e_zero(e_zero),
      .e_zvs(e_zvs), .gates(gates)
   );

   assign g_main    = gates.main;
   assign g_clamp   = gates.clamp;
   assign g_rect    = gates.rect;
   assign cyc_start = gates.start;
endmodule

// File: rtl/zvs_flyback_seq_chk.sv
module zvs_flyback_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic g_main,
   input logic g_clamp,
   input logic g_rect,
   input logic cyc_start,
   input logic cfg_err
);
   p_no_main_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(g_main && g_clamp));
   p_no_main_rect_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(g_main && g_rect));
   p_clamp_rect_r8: assert property (@(posedge clk) disable iff (!rst_n)
      g_clamp |-> g_rect);
   p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !(g_main || g_clamp || g_rect || cyc_start));
   p_main_rise_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(g_main) |-> cyc_start);
   p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);
endmodule

bind zvs_flyback_seq zvs_flyback_seq_chk chk_i (
   .clk(clk), .rst_n(rst_n), .en(en), .g_main(g_main), .g_clamp(g_clamp),
   .g_rect(g_rect), .cyc_start(cyc_start), .cfg_err(cfg_err)
);

// File: tb/zvs_flyback_seq_tb_top.sv
module zvs_flyback_seq_tb_top;
   localparam int CW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic [CW-1:0] period_cnt = '0, duty_cnt = '0, toff_dead_cnt = '0;
   logic [CW-1:0] release_cnt = '0, zvs_cnt = '0, gap_cnt = '0;
   logic g_main, g_clamp, g_rect, cyc_start, cfg_err;

   always #10 clk = ~clk;

   zvs_flyback_seq #(.CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .en(en),
      .period_cnt(period_cnt), .duty_cnt(duty_cnt), .toff_dead_cnt(toff_dead_cnt),
      .release_cnt(release_cnt), .zvs_cnt(zvs_cnt), .gap_cnt(gap_cnt),
      .g_main(g_main), .g_clamp(g_clamp), .g_rect(g_rect),
      .cyc_start(cyc_start), .cfg_err(cfg_err)
   );

   typedef struct {
      logic [3:0] v;
      string      tag;
   } item_t;

   item_t q[$];
   int    checks = 0;
   int    errors = 0;
   bit    started = 0;
   bit    done = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // expected cycle from the requirements: {main, clamp, rect, start}
   task automatic push_cycle(input int p, input int d, input int o, input int r,
                             input int a, input int b, input string tag);
      int ton, busy, len;
      ton  = (d > a + b) ? d - (a + b) : 0;
      busy = ton + o + r + a + b;
      len  = (busy > p) ? busy : p;
      if (len == 0) len = 1;
      for (int i = 0; i < len; i++) begin
         item_t it;
         logic mn, cl, pu;
         mn = i < ton;
         cl = (i >= ton + o) && (i < ton + o + r);
         pu = (i >= len - a - b) && (i < len - b);
         it.v = {mn, cl, cl | pu, i == 0};
         it.tag = tag;
         q.push_back(it);
      end
   endtask

   task automatic set_cfg(input int p, input int d, input int o, input int r,
                          input int a, input int b);
      period_cnt = CW'(p); duty_cnt = CW'(d); toff_dead_cnt = CW'(o);
      release_cnt = CW'(r); zvs_cnt = CW'(a); gap_cnt = CW'(b);
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic drain;
      while (q.size() != 0) tick(1);
      en = 1'b0;
      tick(2);
      check(!(g_main | g_clamp | g_rect | cyc_start), "R1 disable",
            {g_main, g_clamp, g_rect, cyc_start}, 0);
   endtask

   task automatic run(input int p, input int d, input int o, input int r,
                      input int a, input int b, input int n, input string tag);
      en = 1'b0;
      tick(2);
      started = 0;
      set_cfg(p, d, o, r, a, b);
      for (int c = 0; c < n; c++) push_cycle(p, d, o, r, a, b, tag);
      en = 1'b1;
      drain();
   endtask

   // monitor
   always @(negedge clk) begin
      if (q.size() != 0 && (started || cyc_start)) begin
         item_t it;
         started = 1;
         it = q.pop_front();
         check({g_main, g_clamp, g_rect, cyc_start} == it.v, it.tag,
               {g_main, g_clamp, g_rect, cyc_start}, it.v);
      end
   end

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      tick(3);
      check(!(g_main | g_clamp | g_rect | cyc_start), "R1 reset",
            {g_main, g_clamp, g_rect, cyc_start}, 0);
      check(cfg_err == 1'b0, "R10 reset flag", cfg_err, 0);
      rst_n = 1'b1;
      tick(2);

      // R2 R3 R4 R5 R6 R7 R8: nominal pattern
      run(40, 14, 2, 9, 3, 2, 3, "R2-nominal R7");
      // no rectifier-only pulse, R7 with zvs segment zero
      run(20, 6, 1, 4, 0, 1, 2, "R7 zero pulse R5");
      // duty within dead-time segments: no main on-time, R3
      run(16, 3, 1, 3, 2, 2, 2, "R3 no on-time R6");
      check(cfg_err == 1'b0, "R10 no false flag", cfg_err, 0);

      // R9: change settings in the middle of a cycle
      en = 1'b0;
      tick(2);
      started = 0;
      set_cfg(40, 14, 2, 9, 3, 2);
      push_cycle(40, 14, 2, 9, 3, 2, "R9 old cycle");
      push_cycle(20, 6, 1, 4, 0, 1, "R9 new cycle");
      push_cycle(20, 6, 1, 4, 0, 1, "R9 new cycle");
      en = 1'b1;
      while (!started) tick(1);
      tick(3);
      set_cfg(20, 6, 1, 4, 0, 1);
      drain();

      // R10: overrun stretches the cycle and sets the sticky flag
      run(10, 8, 2, 6, 2, 1, 2, "R10 overrun");
      check(cfg_err == 1'b1, "R10 flag set", cfg_err, 1);
      run(20, 6, 1, 4, 0, 1, 1, "R10 after overrun");
      check(cfg_err == 1'b1, "R10 flag sticky", cfg_err, 1);
      rst_n = 1'b0;
      tick(2);
      check(cfg_err == 1'b0, "R10 cleared by reset", cfg_err, 0);
      check(!(g_main | g_clamp | g_rect | cyc_start), "R1 reset again",
            {g_main, g_clamp, g_rect, cyc_start}, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule